// File: doc/BRIEF.md
# Segment Access Gate

This block screens one memory access per cycle against the attributes of the segment it uses, before address translation. It receives the access address (with the segment base already added), the access size, the access kind, and the segment's base, limit and attribute bits. It also receives the processor's mode bits. It decides whether the access raises a general-protection fault. When the access is allowed, it hands the address on and says whether it goes to the paging translation or bypasses it.

The checks run only in protected mode and only outside full 64-bit mode. The limit test covers both expand-up and expand-down segments. It also handles segments whose limit lies numerically below their base, which wrap around the address space. The end address of the access, address plus size, is formed one bit wider than the address, so a carry out of the top bit still counts as crossing the limit.

The result appears on registered outputs one clock after the request.

Top module: `seg_access_gate`

## Requirements
- R1: The outputs are registered with a latency of one cycle. `out_valid` in cycle n+1 equals `req_valid` in cycle n. While `rst` is high, `out_valid`, `out_fault`, `out_to_paging` and `out_addr` are zero.
- R2: When `mode_pe` is 0, no access faults. `out_addr` equals `req_addr` and `out_to_paging` is 0, whatever the attributes, the limit and `mode_pg` are.
- R3: When `mode_lma` and `mode_cs_long` are both 1, no attribute or limit check applies. If either bit is 0 (with `mode_pe` 1), the checks apply.
- R4: A write (`req_kind` = 2'b01) faults when `attr_wr` is 0.
- R5: A read faults when `attr_rd` is 0. A read is `req_kind` 2'b00, and the reserved code 2'b11 is treated as a read. A fetch (`req_kind` = 2'b10) is never refused for lack of `attr_rd`.
- R6: Expand-up segment (`attr_expdn` = 0) with limit ≥ base: the access faults when limit < address + size.
- R7: Expand-up segment with limit < base: the access faults only when limit < address + size and, at the same time, address < base.
- R8: Expand-down segment (`attr_expdn` = 1) with limit ≥ base: the access faults when address ≤ limit and address + size ≥ base.
- R9: Expand-down segment with limit < base: the access faults when address ≤ limit or address + size ≥ base.
- R10: The address + size sum is ADDR_W+1 bits wide. An access whose end carries past the top of the address space exceeds even an all-ones limit.
- R11: On a fault, `out_err_code` is 0, `out_addr` is 0 and `out_to_paging` is 0.
- R12: In protected mode, an access that does not fault leaves with `out_addr` equal to `req_addr`, and with `out_to_paging` equal to `mode_pg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address, segment base already added |
| req_size | input | SIZE_W | Access size in bytes |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| attr_rd | input | 1 | Segment readable |
| attr_wr | input | 1 | Segment writable |
| attr_expdn | input | 1 | Segment expands down |
| mode_pe | input | 1 | Protection enabled |
| mode_lma | input | 1 | Long mode active |
| mode_cs_long | input | 1 | Code segment is 64-bit |
| mode_pg | input | 1 | Paging enabled |
| out_valid | output | 1 | Result valid |
| out_fault | output | 1 | General-protection fault |
| out_err_code | output | ERR_W | Fault error code (always zero) |
| out_addr | output | ADDR_W | Address passed on, zero on fault |
| out_to_paging | output | 1 | Address must go through paging translation |

## Verification
A rights violation and a limit violation can occur in the same access. Routing can also collide with a fault, for example a limit overflow while paging is enabled. The bench provokes the first collision with a write to a read-only segment that also crosses the limit, and expects a single fault flag. It provokes the second with faulting accesses issued while `mode_pg` is 1, and judges that `out_to_paging` stays low and the address is zeroed. The mode-skip case is provoked with the same violating access: it must fault when only one of the two long-mode bits is set, and pass when both are set.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic expdn;
  } seg_attr_t;

  typedef struct packed {
    logic pe;
    logic lma;
    logic cs_long;
    logic pg;
  } cpu_mode_t;

endpackage

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import seg_chk_pkg::*;
(
  input  logic [1:0] kind,
  input  seg_attr_t  attr,
  output logic       rights_fault
);
  acc_kind_e k;
  logic is_write;
  logic is_read;

  always_comb begin
    k        = acc_kind_e'(kind);
    is_write = (k == ACC_WRITE);
    is_read  = (k == ACC_READ) || (k == ACC_RSVD);
    rights_fault = (is_write && !attr.wr) || (is_read && !attr.rd);
  end
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              expdn,
  output logic              bound_fault
);
  localparam int SUM_W = ADDR_W + 1;
  localparam int PAD_W = SUM_W - SIZE_W;

  logic [SUM_W-1:0] end_sum;
  logic [SUM_W-1:0] limit_w;
  logic [SUM_W-1:0] base_w;
  logic wraps;
  logic over_top;
  logic below_base;
  logic at_or_under_lim;
  logic end_reaches_base;

  always_comb begin
    end_sum          = {1'b0, addr} + {{PAD_W{1'b0}}, size};
    limit_w          = {1'b0, limit};
    base_w           = {1'b0, base};
    wraps            = (limit < base);
    over_top         = (limit_w < end_sum);
    below_base       = (addr < base);
    at_or_under_lim  = (addr <= limit);
    end_reaches_base = (end_sum >= base_w);
    if (!expdn) begin
      bound_fault = wraps ? (over_top && below_base) : over_top;
    end else begin
      bound_fault = wraps ? (at_or_under_lim || end_reaches_base)
                          : (at_or_under_lim && end_reaches_base);
    end
  end
endmodule

// File: rtl/seg_route_sel.sv
module seg_route_sel
  import seg_chk_pkg::*;
(
  input  cpu_mode_t mode,
  output logic      check_en,
  output logic      paging_sel
);
  always_comb begin
    check_en   = mode.pe && !(mode.lma && mode.cs_long);
    paging_sel = mode.pe && mode.pg;
  end
endmodule

// File: rtl/seg_access_gate.sv
module seg_access_gate
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              attr_rd,
  input  logic              attr_wr,
  input  logic              attr_expdn,
  input  logic              mode_pe,
  input  logic              mode_lma,
  input  logic              mode_cs_long,
  input  logic              mode_pg,
  output logic              out_valid,
  output logic              out_fault,
  output logic [ERR_W-1:0]  out_err_code,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_to_paging
);
  seg_attr_t attr;
  cpu_mode_t mode;
  logic rights_f;
  logic bound_f;
  logic check_en;
  logic paging_sel;
  logic fault_c;

  assign attr = '{rd: attr_rd, wr: attr_wr, expdn: attr_expdn};
  assign mode = '{pe: mode_pe, lma: mode_lma, cs_long: mode_cs_long, pg: mode_pg};

  seg_rights_check u_rights (
    .kind         (req_kind),
    .attr         (attr),
    .rights_fault (rights_f)
  );

  seg_bound_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_bound (
    .addr        (req_addr),
    .size        (req_size),
    .base        (seg_base),
    .limit       (seg_limit),
    .expdn       (attr_expdn),
    .bound_fault (bound_f)
  );

  seg_route_sel u_route (
    .mode       (mode),
    .check_en   (check_en),
    .paging_sel (paging_sel)
  );

  assign fault_c = check_en && (rights_f || bound_f);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_fault     <= 1'b0;
      out_addr      <= '0;
      out_to_paging <= 1'b0;
    end else begin
      out_valid     <= req_valid;
      out_fault     <= req_valid && fault_c;
      out_addr      <= (req_valid && !fault_c) ? req_addr : '0;
      out_to_paging <= req_valid && !fault_c && paging_sel;
    end
  end

  // Every protection fault reported here carries a zero code.
  assign out_err_code = '0;
endmodule

// File: rtl/seg_access_gate_chk.sv
module seg_access_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] seg_base,
  input logic [ADDR_W-1:0] seg_limit,
  input logic              attr_rd,
  input logic              attr_wr,
  input logic              attr_expdn,
  input logic              mode_pe,
  input logic              mode_lma,
  input logic              mode_cs_long,
  input logic              mode_pg,
  input logic              out_valid,
  input logic              out_fault,
  input logic [ERR_W-1:0]  out_err_code,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_to_paging
);
  a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  a_r2_real_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mode_pe) |=>
      (!out_fault && !out_to_paging && out_addr == $past(req_addr)));

  a_r3_long_skip: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_pe && mode_lma && mode_cs_long) |=> !out_fault);

  a_r4_write_ro: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode_pe && !(mode_lma && mode_cs_long) &&
     req_kind == 2'b01 && !attr_wr) |=> out_fault);

  a_r11_fault_clean: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (!out_to_paging && out_err_code == '0 && out_addr == '0));

  a_r12_no_paging: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mode_pg) |=> !out_to_paging);

  // R6 to R10 depend on arithmetic comparisons of the inputs. They are
  // checked by the directed bench.
  logic unused_ok;
  assign unused_ok = ^{req_size, seg_base, seg_limit, attr_rd, attr_expdn};
endmodule

bind seg_access_gate seg_access_gate_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ERR_W(ERR_W)
) u_chk (.*);

// File: tb/seg_access_gate_test.sv
module seg_access_gate_test;
  localparam int AW = 32;
  localparam int SW = 4;
  localparam int EW = 16;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic [SW-1:0] req_size;
  logic [1:0] req_kind;
  logic [AW-1:0] seg_base;
  logic [AW-1:0] seg_limit;
  logic attr_rd;
  logic attr_wr;
  logic attr_expdn;
  logic mode_pe;
  logic mode_lma;
  logic mode_cs_long;
  logic mode_pg;
  logic out_valid;
  logic out_fault;
  logic [EW-1:0] out_err_code;
  logic [AW-1:0] out_addr;
  logic out_to_paging;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seg_access_gate #(.ADDR_W(AW), .SIZE_W(SW), .ERR_W(EW)) uut (.*);

  task automatic setup(input logic pe, input logic lma, input logic csl,
                       input logic pg, input logic rd, input logic wr,
                       input logic dn, input logic [AW-1:0] b,
                       input logic [AW-1:0] l);
    mode_pe = pe; mode_lma = lma; mode_cs_long = csl; mode_pg = pg;
    attr_rd = rd; attr_wr = wr; attr_expdn = dn;
    seg_base = b; seg_limit = l;
  endtask

  task automatic access(input string tag, input logic [1:0] kind,
                        input logic [AW-1:0] a, input logic [SW-1:0] sz,
                        input logic exp_fault, input logic exp_pg);
    logic [AW-1:0] exp_addr;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    exp_addr = exp_fault ? '0 : a;
    tests++;
    if (out_valid !== 1'b1 || out_fault !== exp_fault ||
        out_addr !== exp_addr || out_to_paging !== exp_pg ||
        out_err_code !== '0) begin
      fails++;
      $display("FAIL %s: valid=%b fault=%b addr=%h pg=%b err=%h expected valid=1 fault=%b addr=%h pg=%b err=0",
               tag, out_valid, out_fault, out_addr, out_to_paging, out_err_code,
               exp_fault, exp_addr, exp_pg);
    end
  endtask

  task automatic t_reset;
    tests++;
    if (out_valid !== 1'b0 || out_fault !== 1'b0 || out_addr !== '0 ||
        out_to_paging !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: valid=%b fault=%b addr=%h pg=%b expected all 0",
               out_valid, out_fault, out_addr, out_to_paging);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle: valid=%b expected 0", out_valid);
    end
  endtask

  task automatic t_real;
    setup(0, 0, 0, 1, 0, 0, 0, 32'h2000, 32'h10);
    access("R2 real-mode write", 2'b01, 32'h1234, 4, 0, 0);
    access("R2 real-mode read", 2'b00, 32'hFFFF_FFFE, 4, 0, 0);
  endtask

  task automatic t_long;
    setup(1, 1, 1, 1, 1, 0, 0, 32'h0, 32'h100);
    access("R3 both long bits skip", 2'b01, 32'h200, 4, 0, 1);
    setup(1, 1, 0, 1, 1, 0, 0, 32'h0, 32'h100);
    access("R3 cs not long checks", 2'b01, 32'h10, 4, 1, 0);
    setup(1, 0, 1, 0, 1, 0, 0, 32'h0, 32'h100);
    access("R3 lma clear checks", 2'b01, 32'h10, 4, 1, 0);
  endtask

  task automatic t_rights;
    setup(1, 0, 0, 0, 1, 0, 0, 32'h0, 32'hFFFF);
    access("R4 write read-only", 2'b01, 32'h40, 4, 1, 0);
    setup(1, 0, 0, 0, 1, 1, 0, 32'h0, 32'hFFFF);
    access("R4 write writable", 2'b01, 32'h40, 4, 0, 0);
    setup(1, 0, 0, 0, 0, 1, 0, 32'h0, 32'hFFFF);
    access("R5 read unreadable", 2'b00, 32'h40, 4, 1, 0);
    access("R5 reserved kind as read", 2'b11, 32'h40, 4, 1, 0);
    access("R5 fetch unreadable", 2'b10, 32'h40, 4, 0, 0);
    // rights and limit violation at once: a single fault
    setup(1, 0, 0, 1, 1, 0, 0, 32'h0, 32'h100);
    access("R4 write ro over limit", 2'b01, 32'h200, 4, 1, 0);
  endtask

  task automatic t_up;
    setup(1, 0, 0, 0, 1, 1, 0, 32'h1000, 32'h1FFF);
    access("R6 inside", 2'b00, 32'h1FF0, 8, 0, 0);
    access("R6 end equals limit", 2'b00, 32'h1FFB, 4, 0, 0);
    access("R6 past limit", 2'b00, 32'h1FFC, 4, 1, 0);
    access("R6 below base allowed", 2'b00, 32'h0100, 4, 0, 0);
  endtask

  task automatic t_up_wrap;
    setup(1, 0, 0, 0, 1, 1, 0, 32'h8000, 32'h1000);
    access("R7 low part", 2'b00, 32'h0100, 4, 0, 0);
    access("R7 hole", 2'b00, 32'h2000, 4, 1, 0);
    access("R7 above base", 2'b00, 32'h9000, 4, 0, 0);
  endtask

  task automatic t_down;
    setup(1, 0, 0, 0, 1, 1, 1, 32'h1000, 32'h3000);
    access("R8 in hole", 2'b00, 32'h2000, 4, 1, 0);
    access("R8 above limit", 2'b00, 32'h3001, 4, 0, 0);
    access("R8 under base", 2'b00, 32'h0100, 4, 0, 0);
  endtask

  task automatic t_down_wrap;
    setup(1, 0, 0, 0, 1, 1, 1, 32'h9000, 32'h2000);
    access("R9 under limit", 2'b00, 32'h1000, 4, 1, 0);
    access("R9 window", 2'b00, 32'h5000, 4, 0, 0);
    access("R9 end hits base", 2'b00, 32'h8FFE, 4, 1, 0);
  endtask

  task automatic t_carry;
    setup(1, 0, 0, 1, 1, 1, 0, 32'h0, 32'hFFFF_FFFF);
    access("R10 carry out faults", 2'b00, 32'hFFFF_FFFE, 4, 1, 0);
    access("R10 near top fits", 2'b00, 32'hFFFF_FFF0, 4, 0, 1);
  endtask

  task automatic t_route;
    setup(1, 0, 0, 0, 1, 1, 0, 32'h0, 32'hFFFF);
    access("R12 paging off", 2'b00, 32'h0ABC, 2, 0, 0);
    setup(1, 0, 0, 1, 1, 1, 0, 32'h0, 32'hFFFF);
    access("R12 paging on", 2'b00, 32'h0ABC, 2, 0, 1);
    access("R11 fault with paging on", 2'b00, 32'h1FFFF, 2, 1, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b1; req_addr = 32'h55; req_size = 4;
    req_kind = 2'b00;
    setup(0, 0, 0, 0, 1, 1, 0, 0, 32'hFFFF);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0; req_valid = 1'b0;
    t_idle();
    t_real();
    t_long();
    t_rights();
    t_up();
    t_up_wrap();
    t_down();
    t_down_wrap();
    t_carry();
    t_route();
    t_idle();
    finish_run();
  end

  initial begin
    #400000;
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule